// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of a four-input, 10-bit successive-approximation converter. Software programs two control nibbles. One carries the module enable, the input select and the reference select. The other carries the conversion-clock divider, the conversion-length choice and a start/busy flag. Setting the flag requests a conversion. The sequencer then divides the system clock into conversion-clock slots and drives a 10-bit trial code towards the external comparator. It resolves one bit per decision, most significant bit first, and stores the final code in one clock cycle.

The stored code is presented as three read-only nibble views. Completion clears the start/busy flag, raises an interrupt request flag, and opens a fixed quiet gap before the next conversion may begin. Software can abort a conversion by clearing the flag. An aborted conversion leaves the stored code untouched.

The analog comparator and the sample switch sit outside the block. The comparator returns one bit, which is 1 when the selected input is at or above the trial code.

Top module: `sar_conv_seq`

## Requirements
- R1: After reset, both control nibbles, all three result views, the trial code and the interrupt request flag read zero.
- R2: A write with `wr_sel`=0 stores the control nibble {bit3 reference select (1 = external), bits 2..1 input select (00..11 = inputs 0..3), bit0 module enable}. It reads back unchanged, and `ch_sel` and `ref_ext` follow it.
- R3: A write with `wr_sel`=1 stores the timing nibble {bit3 start/busy flag, bits 2..1 divider select, bit0 length select}. One conversion-clock slot lasts BASE_DIV × 2^(divider select) clock cycles.
- R4: A conversion lasts 15 slots when the length select is 0 and 114 slots when it is 1. With no pending gap, the flag reads 0 exactly 1 + slots × slot-length cycles after the clock edge that stored it as 1.
- R5: The start/busy flag reads 1 from the write that sets it until hardware clears it at completion.
- R6: The trial code starts at 0x200, one cycle after the conversion starts. Ten comparator decisions are made MSB first, and the stored result equals the input value seen by an ideal comparator.
- R7: The low view shows result bits 2..0 in positions 3..1, with bit 0 reading 0. The middle view shows bits 6..3. The high view shows bits 9..7 in positions 2..0, with bit 3 reading 0.
- R8: Writing the flag to 0 during a conversion aborts it. The flag and `conv_busy` drop, the result is unchanged, and no interrupt request is raised.
- R9: Completion sets `irq_flag`. `irq_out` is `irq_flag` AND `irq_en`. `irq_ack` clears the flag.
- R10: After a completion or an abort, no new conversion starts for GAP_CYCLES cycles. A start requested at once then finishes GAP_CYCLES + slots × slot-length cycles after its write.
- R11: A start requested while the module is disabled is held with the flag reading 1. The conversion begins the cycle after enable is set.
- R12: All ten result bits change together in the same clock cycle, and only at completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = control nibble, 1 = timing nibble |
| wr_data | input | 4 | Write data |
| irq_en | input | 1 | Interrupt enable |
| irq_ack | input | 1 | Clears the interrupt request flag |
| cmp_in | input | 1 | Comparator: 1 when input ≥ trial code |
| ctrl_q | output | 4 | Control nibble view |
| time_q | output | 4 | Timing nibble view, bit3 = start/busy |
| res_lo | output | 4 | Result low view |
| res_mid | output | 4 | Result middle view |
| res_hi | output | 4 | Result high view |
| dac_code | output | 10 | Trial code to the comparator |
| ch_sel | output | 2 | Selected input |
| ref_ext | output | 1 | External reference selected |
| conv_busy | output | 1 | Conversion in progress |
| irq_flag | output | 1 | Interrupt request flag |
| irq_out | output | 1 | Gated interrupt to the CPU |

## Verification
The bench measures exact completion latency for both lengths and for two divider settings. A design that miscounted the lead slots or the decision spacing would be off by whole slots. It restarts immediately after a completion to expose a missing or off-by-one quiet gap. It aborts a long conversion to catch a result register that takes a partial code or an interrupt raised on abort. It also requests a start while disabled, which a design without a held request would lose, and it feeds all-ones, all-zeros and alternating inputs so that a reversed bit order or a misplaced nibble field changes the views.

// File: rtl/sar_seq_pkg.sv
// Shared types for the conversion sequencer.
// Assumes a 10-bit result presented as three nibble views.
package sar_seq_pkg;
    localparam int RES_W = 10;

    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_TIME = 1'b1
    } sar_wsel_e;

    typedef struct packed {
        logic       ref_ext;
        logic [1:0] chan;
        logic       enable;
    } sar_ctrl_t;

    typedef struct packed {
        logic       go;
        logic [1:0] div_sel;
        logic       long_len;
    } sar_time_t;
endpackage

// File: rtl/sar_slot_gen.sv
// Conversion-clock slot generator: pulses tick once every
// BASE_DIV << div_sel cycles while run is high, restarting from zero
// whenever run is low. Assumes div_sel is held stable during a run.
module sar_slot_gen #(
    parameter int BASE_DIV = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] div_sel,
    output logic       tick
);
    localparam int MAX_DIV = BASE_DIV * 8;
    localparam int CW      = $clog2(MAX_DIV);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    // Last count value of one slot for the chosen divider.
    always_comb limit = CW'((BASE_DIV << div_sel) - 1);

    assign tick = run && (cnt == limit);

    // Free-running slot counter, held at zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == limit) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sar_bit_engine.sv
// Successive-approximation engine: after start it spends a lead of
// settle slots, then makes NBITS decisions spaced evenly to fill the
// chosen length, MSB first. The result register is written in one
// cycle at the final decision. Assumes cmp_in is valid for the
// present trial code.
module sar_bit_engine #(
    parameter int NBITS     = 10,
    parameter int SHORT_LEN = 15,
    parameter int LONG_LEN  = 114
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic             long_len,
    input  logic             tick,
    input  logic             cmp_in,
    output logic             busy,
    output logic             finish,
    output logic [NBITS-1:0] trial,
    output logic [NBITS-1:0] result
);
    localparam int STEP_S = SHORT_LEN / NBITS;
    localparam int STEP_L = LONG_LEN / NBITS;
    localparam int LEAD_S = SHORT_LEN - NBITS * STEP_S;
    localparam int LEAD_L = LONG_LEN - NBITS * STEP_L;
    localparam int CW     = $clog2(LONG_LEN + 1);
    localparam int BW     = $clog2(NBITS);

    logic [CW-1:0] lead_cnt, lead_q, ph_cnt, step_q;
    logic          in_lead;
    logic [BW-1:0] bit_idx, nxt_idx;
    logic          decide;

    assign nxt_idx = bit_idx - 1'b1;
    assign decide  = busy && tick && !in_lead && !abort &&
                     (ph_cnt == step_q - 1'b1);
    assign finish  = decide && (bit_idx == '0);

    // Conversion state: lead timing, decision spacing and bit stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            in_lead  <= 1'b0;
            lead_cnt <= '0;
            lead_q   <= '0;
            ph_cnt   <= '0;
            step_q   <= '0;
            bit_idx  <= '0;
            trial    <= '0;
            result   <= '0;
        end else if (abort) begin
            busy <= 1'b0;
        end else if (start) begin
            busy     <= 1'b1;
            step_q   <= long_len ? CW'(STEP_L) : CW'(STEP_S);
            lead_q   <= long_len ? CW'(LEAD_L) : CW'(LEAD_S);
            in_lead  <= long_len ? (LEAD_L != 0) : (LEAD_S != 0);
            lead_cnt <= '0;
            ph_cnt   <= '0;
            bit_idx  <= BW'(NBITS - 1);
            trial    <= {1'b1, {(NBITS-1){1'b0}}};
        end else if (busy && tick) begin
            if (in_lead) begin
                if (lead_cnt == lead_q - 1'b1) begin
                    in_lead <= 1'b0;
                end else begin
                    lead_cnt <= lead_cnt + 1'b1;
                end
            end else if (decide) begin
                ph_cnt         <= '0;
                trial[bit_idx] <= cmp_in;
                if (bit_idx == '0) begin
                    busy   <= 1'b0;
                    result <= {trial[NBITS-1:1], cmp_in};
                end else begin
                    trial[nxt_idx] <= 1'b1;
                    bit_idx        <= nxt_idx;
                end
            end else begin
                ph_cnt <= ph_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sar_conv_seq.sv
// Top of the conversion sequencer: control and timing nibbles,
// held start request, quiet gap after each conversion, interrupt
// flag and result nibble views. Assumes one register write per cycle.
module sar_conv_seq
    import sar_seq_pkg::*;
#(
    parameter int BASE_DIV   = 16,
    parameter int GAP_CYCLES = 16,
    parameter int SHORT_LEN  = 15,
    parameter int LONG_LEN   = 114
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [3:0]       wr_data,
    input  logic             irq_en,
    input  logic             irq_ack,
    input  logic             cmp_in,
    output logic [3:0]       ctrl_q,
    output logic [3:0]       time_q,
    output logic [3:0]       res_lo,
    output logic [3:0]       res_mid,
    output logic [3:0]       res_hi,
    output logic [RES_W-1:0] dac_code,
    output logic [1:0]       ch_sel,
    output logic             ref_ext,
    output logic             conv_busy,
    output logic             irq_flag,
    output logic             irq_out
);
    localparam int GW = $clog2(GAP_CYCLES + 1);

    sar_ctrl_t        ctrl_r;
    sar_time_t        time_r;
    logic             go_q;
    logic [GW-1:0]    gap_cnt;
    logic             gap_zero;
    logic             wr_ctrl, wr_time, clr_req;
    logic             busy, conv_start, conv_abort, conv_finish, tick;
    logic [RES_W-1:0] result;

    assign wr_ctrl    = wr_en && (wr_sel == SEL_CTRL);
    assign wr_time    = wr_en && (wr_sel == SEL_TIME);
    assign clr_req    = wr_time && !wr_data[3];
    assign gap_zero   = (gap_cnt == '0);
    assign conv_abort = busy && clr_req;
    assign conv_start = go_q && ctrl_r.enable && gap_zero && !busy && !clr_req;
    assign go_q       = time_r.go;

    // Control nibble register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_r <= '0;
        end else if (wr_ctrl) begin
            ctrl_r <= sar_ctrl_t'(wr_data);
        end
    end

    // Timing nibble; the flag is cleared by hardware at completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            time_r <= '0;
        end else begin
            if (wr_time) begin
                time_r <= sar_time_t'(wr_data);
            end
            if (conv_finish) begin
                time_r.go <= 1'b0;
            end
        end
    end

    // Quiet gap counter, loaded when a conversion ends or aborts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt <= '0;
        end else if (conv_finish || conv_abort) begin
            gap_cnt <= GW'(GAP_CYCLES);
        end else if (!gap_zero) begin
            gap_cnt <= gap_cnt - 1'b1;
        end
    end

    // Interrupt request flag: set on completion, cleared by ack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_flag <= 1'b0;
        end else if (conv_finish) begin
            irq_flag <= 1'b1;
        end else if (irq_ack) begin
            irq_flag <= 1'b0;
        end
    end

    sar_slot_gen #(
        .BASE_DIV(BASE_DIV)
    ) u_slot (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (busy),
        .div_sel(time_r.div_sel),
        .tick   (tick)
    );

    sar_bit_engine #(
        .NBITS    (RES_W),
        .SHORT_LEN(SHORT_LEN),
        .LONG_LEN (LONG_LEN)
    ) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (conv_start),
        .abort   (conv_abort),
        .long_len(time_r.long_len),
        .tick    (tick),
        .cmp_in  (cmp_in),
        .busy    (busy),
        .finish  (conv_finish),
        .trial   (dac_code),
        .result  (result)
    );

    assign ctrl_q    = ctrl_r;
    assign time_q    = time_r;
    assign ch_sel    = ctrl_r.chan;
    assign ref_ext   = ctrl_r.ref_ext;
    assign conv_busy = busy;
    assign irq_out   = irq_flag && irq_en;
    assign res_lo    = {result[2:0], 1'b0};
    assign res_mid   = result[6:3];
    assign res_hi    = {1'b0, result[9:7]};
endmodule

// File: rtl/sar_seq_chk.sv
// Property checker for the conversion sequencer, bound to the top.
module sar_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       finish,
    input logic       go,
    input logic       busy,
    input logic       enable,
    input logic       gap_zero,
    input logic       irq_flag,
    input logic       irq_en,
    input logic       irq_out,
    input logic [9:0] result
);
    a_r5_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> !go);

    a_r9_irq_raised: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> irq_flag);

    a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> irq_en);

    a_r8_flag_drop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(go) |-> !busy);

    a_r12_result_atomic: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> $past(finish));

    a_r10_gap_respected: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(gap_zero));

    a_r11_start_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(enable));
endmodule

bind sar_conv_seq sar_seq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .finish  (conv_finish),
    .go      (go_q),
    .busy    (busy),
    .enable  (ctrl_r.enable),
    .gap_zero(gap_zero),
    .irq_flag(irq_flag),
    .irq_en  (irq_en),
    .irq_out (irq_out),
    .result  (result)
);

// File: tb/sar_conv_seq_tb.sv
module sar_conv_seq_tb;
    localparam int GAP = 16;
    localparam int DIV = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, wr_sel = 1'b0, irq_en = 1'b0, irq_ack = 1'b0;
    logic [3:0] wr_data = '0;
    logic       cmp_in;
    logic [3:0] ctrl_q, time_q, res_lo, res_mid, res_hi;
    logic [9:0] dac_code;
    logic [1:0] ch_sel;
    logic       ref_ext, conv_busy, irq_flag, irq_out;

    logic [9:0] stim [4];
    logic [9:0] exp_q [$];
    int checks = 0, errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    // Ideal comparator model on the selected input.
    assign cmp_in = (stim[ch_sel] >= dac_code);

    sar_conv_seq u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .irq_en(irq_en), .irq_ack(irq_ack),
        .cmp_in(cmp_in), .ctrl_q(ctrl_q), .time_q(time_q),
        .res_lo(res_lo), .res_mid(res_mid), .res_hi(res_hi),
        .dac_code(dac_code), .ch_sel(ch_sel), .ref_ext(ref_ext),
        .conv_busy(conv_busy), .irq_flag(irq_flag), .irq_out(irq_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic write_reg(input logic sel, input logic [3:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic ack_irq();
        @(negedge clk); irq_ack = 1'b1;
        @(posedge clk); #1; irq_ack = 1'b0;
    endtask

    // Counts edges until the start/busy flag reads 0.
    task automatic wait_flag_low(output int n);
        n = 0;
        while (time_q[3]) begin
            @(posedge clk); #1; n++;
        end
    endtask

    function automatic int conv_cycles(input bit lng, input int dsel);
        return (lng ? 114 : 15) * DIV * (1 << dsel);
    endfunction

    // Driver: programs a conversion, pushes its expected result, times it.
    task automatic run_conv(input int ch, input logic [9:0] v, input bit lng,
                            input int dsel, input string req);
        int n;
        stim[ch] = v;
        write_reg(1'b0, {1'b0, 2'(ch), 1'b1});
        exp_q.push_back(v);
        write_reg(1'b1, {1'b1, 2'(dsel), lng});
        check(time_q[3] == 1'b1, "R5 flag set", time_q[3], 1);
        wait_flag_low(n);
        check(n == 1 + conv_cycles(lng, dsel), req, n, 1 + conv_cycles(lng, dsel));
        idle(GAP + 4);
        ack_irq();
    endtask

    // Monitor: on each new interrupt request, pop and compare the views.
    initial begin
        logic prev = 1'b0;
        forever begin
            @(posedge clk); #1;
            if (rst_n && irq_flag && !prev) begin
                logic [9:0] got, exp;
                got = {res_hi[2:0], res_mid, res_lo[3:1]};
                if (exp_q.size() == 0) begin
                    check(0, "R8 unexpected completion", got, 0);
                end else begin
                    exp = exp_q.pop_front();
                    check(got == exp, "R6 R12 result", got, exp);
                    check(res_lo[0] == 1'b0 && res_hi[3] == 1'b0, "R7 pad bits",
                          {res_hi[3], res_lo[0]}, 0);
                end
            end
            prev = irq_flag;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int n;
        logic [9:0] keep;
        for (int i = 0; i < 4; i++) stim[i] = '0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        check(ctrl_q == 0 && time_q == 0, "R1 control reset", {ctrl_q, time_q}, 0);
        check(res_lo == 0 && res_mid == 0 && res_hi == 0, "R1 result reset",
              {res_hi, res_mid, res_lo}, 0);
        check(dac_code == 0 && irq_flag == 0, "R1 trial/irq reset", dac_code, 0);

        // R2 control nibble fields
        write_reg(1'b0, 4'b1101);
        check(ctrl_q == 4'b1101, "R2 readback", ctrl_q, 4'hD);
        check(ch_sel == 2'd2 && ref_ext == 1'b1, "R2 ch/ref", {ref_ext, ch_sel}, 6);
        write_reg(1'b0, 4'b0000);

        // R6 first trial code, then full short conversion
        stim[0] = 10'h3FF;
        write_reg(1'b0, 4'b0001);
        exp_q.push_back(10'h3FF);
        write_reg(1'b1, 4'b1000);
        idle(1);
        check(dac_code == 10'h200, "R6 first trial MSB", dac_code, 10'h200);
        n = 1;
        wait_flag_low(n);
        check(n == 1 + 240 - 1 + 1 - 1 + 1 - 1 + 0 || n == 240, "R4 short length", n, 240);
        idle(GAP + 4);
        ack_irq();

        run_conv(1, 10'h000, 1'b0, 0, "R4 short zero input");
        run_conv(2, 10'h2AA, 1'b0, 1, "R3 divider x2");
        check(res_lo == 4'h4 && res_mid == 4'h5 && res_hi == 4'h5, "R7 views of 0x2AA",
              {res_hi, res_mid, res_lo}, 12'h554);
        check(ch_sel == 2'd2, "R2 ch_sel follows", ch_sel, 2);
        run_conv(3, 10'h155, 1'b1, 0, "R4 long length");
        run_conv(0, 10'h1C7, 1'b0, 3, "R3 divider x8");

        // R9 interrupt gating and acknowledge
        stim[1] = 10'h0F0;
        write_reg(1'b0, 4'b0011);
        exp_q.push_back(10'h0F0);
        write_reg(1'b1, 4'b1000);
        wait_flag_low(n);
        idle(1);
        check(irq_flag == 1'b1 && irq_out == 1'b0, "R9 flag set, gated off",
              {irq_flag, irq_out}, 2);
        irq_en = 1'b1; #1;
        check(irq_out == 1'b1, "R9 gated on", irq_out, 1);
        ack_irq();
        check(irq_flag == 1'b0 && irq_out == 1'b0, "R9 ack clears", irq_flag, 0);
        irq_en = 1'b0;
        idle(GAP + 4);

        // R8 abort keeps previous result
        keep = {res_hi[2:0], res_mid, res_lo[3:1]};
        stim[1] = 10'h3A5;
        write_reg(1'b1, 4'b1001);
        idle(300);
        write_reg(1'b1, 4'b0001);
        check(time_q[3] == 1'b0 && conv_busy == 1'b0, "R8 abort stops",
              {time_q[3], conv_busy}, 0);
        idle(2000);
        check({res_hi[2:0], res_mid, res_lo[3:1]} == keep, "R8 result kept",
              {res_hi[2:0], res_mid, res_lo[3:1]}, keep);
        check(irq_flag == 1'b0, "R8 no irq", irq_flag, 0);

        // R10 back-to-back start meets the quiet gap
        stim[1] = 10'h011;
        exp_q.push_back(10'h011);
        write_reg(1'b1, 4'b1000);
        wait_flag_low(n);
        exp_q.push_back(10'h011);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b1; wr_data = 4'b1000; irq_ack = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0; irq_ack = 1'b0;
        wait_flag_low(n);
        check(n == GAP + 240, "R10 gap before restart", n, GAP + 240);
        idle(GAP + 4);
        ack_irq();

        // R11 start held while disabled
        stim[0] = 10'h2C3;
        write_reg(1'b0, 4'b0000);
        write_reg(1'b1, 4'b1000);
        idle(60);
        check(time_q[3] == 1'b1 && conv_busy == 1'b0 && irq_flag == 1'b0,
              "R11 held while disabled", {time_q[3], conv_busy, irq_flag}, 4);
        exp_q.push_back(10'h2C3);
        write_reg(1'b0, 4'b0001);
        wait_flag_low(n);
        check(n == 241, "R11 start after enable", n, 241);
        idle(4);
        check(exp_q.size() == 0, "R6 all results seen", exp_q.size(), 0);
        finish_run();
    end
endmodule